// File: doc/BRIEF.md
# Flow-Through Burst SRAM

A synchronous static memory model with flow-through reads and no bus turnaround penalty. Every enabled clock edge can accept a command, and reads and writes can come in any order. A command is accepted on a rising edge. Read data comes straight out of the array during the cycle after that edge. Write data and its lane enables follow the address by one cycle: the address and lane enables are sampled with the command, and the data word is taken on the next enabled edge. A second address register therefore holds the pending write while the next command is accepted.

A load command starts a burst at an external address. Continue cycles then step a two-bit counter over the low two address bits, so one address serves four accesses. The stepping is either linear or interleaved, chosen by an input. A clock-enable input turns an edge into a stall in which nothing changes. Three chip selects, an output enable and a sleep input decide when the read bus is driven. The storage is 256 words of four 9-bit lanes, and all sizes are parameters.

Top module: `fts_sram`

## Requirements
- R1: An enabled edge with `adv_ld_n` low, all three selects active (`sel1_n`=0, `sel2`=1, `sel3_n`=0), `we_n` high and at least one `be_n` bit low loads `addr` and starts a read. During the following cycle, `rdata` shows the stored word at that address.
- R2: With `lin_mode` high, each enabled continue edge (`adv_ld_n` high) inside a burst moves to the next access. The low two bits are (base + n) mod 4, the upper bits stay fixed, and after the fourth access the sequence wraps to the base.
- R3: With `lin_mode` low, the low two bits of access n are base XOR n.
- R4: An enabled load edge with `we_n` low starts a write. `be_n` is sampled with each write address, and bit i low enables lane i (`wdata` bits 9i+8..9i, parity bit included). The data word is taken from `wdata` on the next enabled edge.
- R5: Reads and writes may alternate on consecutive edges with no idle cycle. A read accepted on the same edge that completes a write to that address returns the new data.
- R6: An edge with `clk_en_n` high is a stall. No command is taken, no write is done and no state changes. A pending write completes at the next enabled edge, using that edge's `wdata`.
- R7: A load edge with any select inactive deselects the device, and nothing is driven afterwards. A continue edge while deselected keeps it deselected. On continue edges the selects and `we_n` are ignored, and the burst keeps its starting kind.
- R8: A write access with all four `be_n` bits high changes no stored data.
- R9: A load edge with `we_n` high and all `be_n` bits high is a dummy read. It starts a burst but never drives `rdata`.
- R10: `rdata_en` is high, and `rdata` is driven, only while `oe_n` is low and the current access is a real read. Otherwise `rdata` is high-impedance.
- R11: While `sleep` is high, edges accept no command, although a pending write's data phase still completes, and the bus is high-impedance. For RECOV (default 2) enabled edges after sleep ends, the bus stays high-impedance and write loads act as deselects, while reads are still accepted.
- R12: After reset the device is deselected, with no pending write and no recovery window, and `rdata_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the edge |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| adv_ld_n | input | 1 | Low loads a new address, high continues the burst |
| we_n | input | 1 | Write enable, active low, sampled on load |
| be_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | Word address |
| lin_mode | input | 1 | High: linear burst, low: interleaved burst |
| sleep | input | 1 | Sleep request, active high |
| oe_n | input | 1 | Output enable, active low |
| wdata | input | LANES*LANE_W | Write data, one cycle after its address |
| rdata | output | LANES*LANE_W | Read data, high-impedance when not driven |
| rdata_en | output | 1 | High while rdata is driven |

## Verification
A read accepted on an edge has its result due in the cycle that follows, so the bench compares `rdata_en` and `rdata` at the next falling edge. At that point a write completed on the same edge must already be visible. The output enable acts within the cycle, so every comparison uses the `oe_n` and `sleep` values held at that falling edge. A stalled edge makes the same value due again one cycle later. The reference model steps only on enabled edges and is compared on every cycle, so each of these timings is checked at its own cycle.

// File: rtl/fts_sram.sv
module fts_sram #(
  parameter int AW = 8,
  parameter int LANES = 4,
  parameter int LANE_W = 9,
  parameter int RECOV = 2,
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             sel3_n,
  input  logic             adv_ld_n,
  input  logic             we_n,
  input  logic [LANES-1:0] be_n,
  input  logic [AW-1:0]    addr,
  input  logic             lin_mode,
  input  logic             sleep,
  input  logic             oe_n,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rdata_en
);
  localparam int DEPTH = 1 << AW;
  localparam int REC_W = $clog2(RECOV + 1);

  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_RD = 2'd1, OP_DUM = 2'd2, OP_WR = 2'd3} op_t;

  logic [DW-1:0] mem [DEPTH];
  op_t op_q, op_n;
  logic [AW-1:0] base_q, base_n, acc_q, acc_n, pend_addr_q;
  logic [1:0] cnt_q, cnt_n, lo;
  logic pend_q;
  logic [LANES-1:0] pend_be_q;
  logic [REC_W-1:0] rec_q;

  wire chip_on = !sel1_n && sel2 && !sel3_n;
  wire recov   = rec_q != '0;

  always_comb begin
    op_n   = op_q;
    base_n = base_q;
    cnt_n  = cnt_q;
    acc_n  = acc_q;
    lo     = '0;
    if (sleep) begin
      op_n = OP_NONE;
    end else if (!adv_ld_n) begin
      base_n = addr;
      cnt_n  = '0;
      acc_n  = addr;
      if (!chip_on)    op_n = OP_NONE;
      else if (!we_n)  op_n = recov ? OP_NONE : OP_WR;
      else             op_n = (&be_n) ? OP_DUM : OP_RD;
    end else if (op_q != OP_NONE) begin
      cnt_n = cnt_q + 2'd1;
      lo    = lin_mode ? base_q[1:0] + cnt_n : base_q[1:0] ^ cnt_n;
      acc_n = {base_q[AW-1:2], lo};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q        <= OP_NONE;
      base_q      <= '0;
      cnt_q       <= '0;
      acc_q       <= '0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_be_q   <= '0;
      rec_q       <= '0;
    end else if (!clk_en_n) begin
      op_q        <= op_n;
      base_q      <= base_n;
      cnt_q       <= cnt_n;
      acc_q       <= acc_n;
      pend_q      <= op_n == OP_WR;
      pend_addr_q <= acc_n;
      pend_be_q   <= ~be_n;
      rec_q       <= sleep ? REC_W'(RECOV) : (recov ? rec_q - REC_W'(1) : rec_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!clk_en_n && pend_q)
      for (int i = 0; i < LANES; i++)
        if (pend_be_q[i]) mem[pend_addr_q][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
  end

  assign rdata_en = !oe_n && op_q == OP_RD && !sleep && !recov;
  assign rdata    = rdata_en ? mem[acc_q] : 'z;

endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          adv_ld_n,
  input logic          we_n,
  input logic          sleep,
  input logic          chip_on,
  input logic [1:0]    op_q,
  input logic [AW-1:0] acc_q,
  input logic [1:0]    cnt_q,
  input logic          pend_q,
  input logic          recov,
  input logic          rdata_en
);
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld_n && !sleep && op_q != 2'd0) |=> cnt_q == $past(cnt_q) + 2'd1); // R2

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(op_q) && $stable(acc_q) && $stable(cnt_q) && $stable(pend_q))); // R6

  AST_DESEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld_n && op_q == 2'd0) |=> op_q == 2'd0); // R7

  AST_WRITE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld_n && chip_on && !we_n && !sleep && !recov) |=> pend_q); // R4

  AST_RECOV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld_n && recov) |=> !pend_q); // R11

  AST_WAKE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sleep) && $past(!clk_en_n)) |-> !rdata_en); // R11
endmodule

bind fts_sram fts_sram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld_n(adv_ld_n), .we_n(we_n),
  .sleep(sleep), .chip_on(chip_on), .op_q(op_q), .acc_q(acc_q), .cnt_q(cnt_q),
  .pend_q(pend_q), .recov(recov), .rdata_en(rdata_en)
);

// File: tb/fts_sram_bench.sv
module fts_sram_bench;
  localparam int PER = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cen_n = 1'b0, s1_n = 1'b0, s2 = 1'b1, s3_n = 1'b0;
  logic ld_n = 1'b1, we_n = 1'b1, lmode = 1'b1, slp = 1'b0, oe_n = 1'b0;
  logic [3:0] be_n = 4'h0;
  logic [7:0] addr = '0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic rdata_en;

  always #(PER/2) clk = ~clk;

  fts_sram u_fts_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(cen_n), .sel1_n(s1_n), .sel2(s2), .sel3_n(s3_n),
    .adv_ld_n(ld_n), .we_n(we_n), .be_n(be_n), .addr(addr), .lin_mode(lmode),
    .sleep(slp), .oe_n(oe_n), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
  );

  int vectors = 0, errors = 0;
  string cur = "R12";

  logic [35:0] mm [256];
  int m_op = 0, m_base = 0, m_cnt = 0, m_acc = 0, m_paddr = 0, m_rec = 0;
  bit m_pend = 0;
  bit [3:0] m_pbe = 0;

  function automatic logic [35:0] pat(int a);
    logic [7:0] b = 8'(a);
    return {4'h9, b, b ^ 8'hA5, ~b, 8'h3C};
  endfunction

  task automatic model_step();
    int lo;
    bit chip;
    if (cen_n) return;
    if (m_pend)
      for (int i = 0; i < 4; i++)
        if (m_pbe[i]) mm[m_paddr][i*9 +: 9] = wdata[i*9 +: 9];
    chip = !s1_n && s2 && !s3_n;
    if (slp) m_op = 0;
    else if (!ld_n) begin
      m_base = addr; m_cnt = 0; m_acc = addr;
      if (!chip) m_op = 0;
      else if (!we_n) m_op = (m_rec > 0) ? 0 : 3;
      else m_op = (be_n == 4'hF) ? 2 : 1;
    end else if (m_op != 0) begin
      m_cnt = (m_cnt + 1) % 4;
      lo = lmode ? ((m_base % 4) + m_cnt) % 4 : ((m_base % 4) ^ m_cnt);
      m_acc = (m_base / 4) * 4 + lo;
    end
    m_pend = (m_op == 3);
    m_paddr = m_acc;
    m_pbe = ~be_n;
    m_rec = slp ? 2 : (m_rec > 0 ? m_rec - 1 : 0);
  endtask

  task automatic check();
    bit exp_en = !oe_n && m_op == 1 && !slp && m_rec == 0;
    vectors++;
    if (rdata_en !== exp_en || (exp_en && rdata !== mm[m_acc])) begin
      errors++;
      $display("FAIL %s t=%0t en=%b/%b data=%h/%h (actual/expected)",
               cur, $time, rdata_en, exp_en, rdata, exp_en ? mm[m_acc] : 36'h0);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check();
  endtask

  task automatic rd(int a, logic [35:0] wd);
    ld_n = 0; we_n = 1; be_n = 4'h0; addr = 8'(a); wdata = wd; tick();
  endtask

  task automatic wr(int a, logic [3:0] be, logic [35:0] wd);
    ld_n = 0; we_n = 0; be_n = be; addr = 8'(a); wdata = wd; tick();
  endtask

  task automatic cont(logic [3:0] be, logic [35:0] wd);
    ld_n = 1; be_n = be; wdata = wd; tick();
  endtask

  task automatic desel(logic [35:0] wd);
    s2 = 0; ld_n = 0; we_n = 1; wdata = wd; tick(); s2 = 1;
  endtask

  initial begin
    #(PER * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur = "R12"; check();

    cur = "R4";
    for (int a = 0; a < 256; a++) wr(a, 4'h0, a == 0 ? 36'h0 : pat(a - 1));
    desel(pat(255));

    cur = "R2"; lmode = 1;
    rd(5, 0); for (int k = 0; k < 4; k++) cont(4'h0, 0);
    rd(6, 0); for (int k = 0; k < 3; k++) cont(4'h0, 0);
    cur = "R1"; rd(200, 0); rd(17, 0);

    cur = "R3"; lmode = 0;
    rd(6, 0); for (int k = 0; k < 3; k++) cont(4'h0, 0);
    rd(9, 0); for (int k = 0; k < 3; k++) cont(4'h0, 0);
    lmode = 1;

    cur = "R5";
    for (int k = 0; k < 8; k++) begin
      wr(10 + k, 4'h0, k == 0 ? 36'h0 : pat(100 + k));
      rd(10 + k, pat(100 + k + 1));
    end
    wr(90, 4'h0, 0); wr(91, 4'h0, pat(190)); rd(90, pat(191)); rd(91, 0);

    cur = "R6";
    rd(20, 0); cen_n = 1; tick(); tick(); cen_n = 0; cont(4'h0, 0); cont(4'h0, 0);
    wr(30, 4'h0, 0); cen_n = 1; wdata = pat(7); tick(); cen_n = 0;
    desel(pat(130)); rd(30, 0);

    cur = "R8";
    wr(40, 4'hF, 0); desel(pat(140)); rd(40, 0);
    cur = "R4";
    wr(41, 4'b1010, 0); desel(pat(141)); rd(41, 0);
    wr(44, 4'h0, 0); cont(4'b0110, pat(144)); cont(4'h0, pat(145)); desel(pat(146));
    rd(44, 0); cont(4'h0, 0); cont(4'h0, 0);

    cur = "R7";
    s1_n = 1; rd(50, 0); cont(4'h0, 0); cont(4'h0, 0); s1_n = 0;
    s2 = 0; rd(51, 0); s2 = 1;
    s3_n = 1; rd(52, 0); cont(4'h0, 0); s3_n = 0;
    wr(60, 4'h0, 0); we_n = 1; s2 = 0;
    cont(4'h0, pat(160)); cont(4'h0, pat(161)); s2 = 1; cont(4'h0, pat(162)); desel(pat(163));
    rd(60, 0); for (int k = 0; k < 3; k++) cont(4'h0, 0);
    rd(64, 0); we_n = 0; cont(4'h0, 0); cont(4'h0, 0);

    cur = "R9";
    ld_n = 0; we_n = 1; be_n = 4'hF; addr = 8'd70; tick();
    cont(4'h0, 0); cont(4'h0, 0); rd(70, 0);

    cur = "R10";
    rd(72, 0); oe_n = 1; cont(4'h0, 0); cont(4'h0, 0); oe_n = 0; cont(4'h0, 0);
    oe_n = 1; rd(73, 0); oe_n = 0; tick();

    cur = "R11";
    rd(85, 0); cont(4'h0, 0);
    wr(80, 4'h0, 0); slp = 1; rd(81, pat(180)); wr(84, 4'h0, 0); tick(); tick();
    slp = 0; wr(82, 4'h0, 0); rd(83, pat(9)); cont(4'h0, 0); cont(4'h0, 0);
    rd(80, 0); rd(82, 0); rd(84, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule